// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache with Uncached Window

This block sits between a processor's data port and an internal memory bus. Reads that fall in the cacheable address space are served from a four-way set-associative store of 16-byte lines. A read miss stalls the processor while the whole line is brought in, one 32-bit word at a time. The way that receives the line is picked by a three-bit tree approximation of least-recently-used order. Writes are write-through and never allocate a line.

One fixed upper address bit marks an uncached window. An access with that bit set goes to the memory bus as a single word transfer with its address unchanged, and the cache contents are left alone. Both windows alias the same physical memory, so a cached copy can go stale when the uncached window is written.

An atomic test-and-set is carried out by the processor as a read followed by a write to the same address. The cache handles the two halves as ordinary independent accesses.

Top module: `sa4_cache`

## Requirements
- R1: After reset, every way of every set is invalid, `cpu_ready` is low and `mem_req` is low.
- R2: A cacheable read that hits returns the stored word with `cpu_ready` high in the same cycle as the request, and makes no memory transfer. `cpu_ready` is never high without `cpu_req`.
- R3: A cacheable read miss issues exactly four memory reads to the line base with address bits 3:2 stepping 0, 1, 2, 3 and bit 29 cleared. The read completes only after the fourth word is installed, and later reads of that line hit.
- R4: On a miss, the lowest-numbered invalid way of the set is filled. When all four ways are valid, the victim comes from the set's tree bits t[2:0]: if t0=0 the victim is way t1 (way 0 or 1); if t0=1 it is way 2+t2.
- R5: Every cacheable read hit, write hit and refill completion updates the tree so that it points away from the way just used. A use of way 0 or 1 sets t0=1 and t1 to the other way of that pair. A use of way 2 or 3 sets t0=0 and t2 to the other way of its pair. Tree bits reset to zero.
- R6: An access with address bit 29 set is uncached. A read makes one memory read with the CPU address unchanged and passes the returned word to `cpu_rdata`. Valid bits, tags, tree bits and data are not changed.
- R7: An uncached write makes one memory write of `cpu_wdata` to the CPU address and never writes the data array, even when the aliased line is present. A later cacheable read of that line still returns the old word.
- R8: A cacheable write makes one memory write and completes with the memory handshake. On a hit it also updates the matching word. On a miss it allocates nothing, so the next read of that address misses.
- R9: A test-and-set made of a read and a write to the same cacheable address behaves as two ordinary accesses: the read reports the old word, and a following read hits and returns the written word.
- R10: Addresses decompose as word select in bits 3:2, set index in bits 9:4 (64 sets) and tag in bits 31:10 with bit 29 forced to zero, so the two windows share lines.
- R11: Once `mem_req` is raised it stays high, with a stable address and direction, until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned; bit 29 selects the uncached window |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high on a read |
| cpu_ready | output | 1 | One-cycle completion of the current access |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer direction, 1 = write |
| mem_addr | output | 32 | Memory transfer address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | One-cycle completion of a memory transfer |

## Verification
A corrupted tag, valid bit or tree bit shows up at the memory port before it shows up in the data. Either a refill burst appears where a silent hit was due, or it is missing where one was due, or the wrong line is evicted and a later reuse refills. The bench therefore compares the exact list of memory transfers of every access, not only the returned word. A bad data-array word shows on `cpu_rdata` at the next hit on it, which can be hundreds of cycles later. Stale aliases after uncached writes are exercised on purpose, because such an error only shows when the cached window is read again.

// File: rtl/sa4_cache_pkg.sv
package sa4_cache_pkg;

  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SINGLE = 2'd1,
    ST_FILL   = 2'd2
  } ctrl_state_e;

  // victim from the three tree bits
  function automatic logic [WAY_W-1:0] tree_pick(input logic [2:0] t);
    tree_pick = t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  // steer the tree away from the way just used
  function automatic logic [2:0] tree_touch(input logic [2:0] t, input logic [WAY_W-1:0] w);
    logic [2:0] r;
    r = t;
    if (!w[1]) begin
      r[0] = 1'b1;
      r[1] = ~w[0];
    end else begin
      r[0] = 1'b0;
      r[2] = ~w[0];
    end
    tree_touch = r;
  endfunction

  function automatic logic [WAY_W-1:0] way_of(input logic [NUM_WAYS-1:0] hv);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (hv[i]) r = WAY_W'(i);
    end
    way_of = r;
  endfunction

endpackage

// File: rtl/sa4_tag_store.sv
module sa4_tag_store
  import sa4_cache_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    lk_idx,
  input  logic [TAG_W-1:0]    lk_tag,
  output logic [NUM_WAYS-1:0] hit_vec,
  output logic [WAY_W-1:0]    victim,
  input  logic                touch_en,
  input  logic [WAY_W-1:0]    touch_way,
  input  logic                install_en,
  input  logic [WAY_W-1:0]    install_way
);

  logic [NUM_WAYS-1:0] valid_q [SETS];
  logic [2:0]          tree_q  [SETS];
  logic [TAG_W-1:0]    tag_q   [SETS][NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  always_comb begin
    victim = tree_pick(tree_q[lk_idx]);
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_q[lk_idx][w]) victim = WAY_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        tree_q[s]  <= '0;
      end
    end else begin
      if (install_en) valid_q[lk_idx][install_way] <= 1'b1;
      if (touch_en)   tree_q[lk_idx] <= tree_touch(tree_q[lk_idx], touch_way);
    end
  end

  always_ff @(posedge clk) begin
    if (install_en) tag_q[lk_idx][install_way] <= lk_tag;
  end

endmodule

// File: rtl/sa4_data_store.sv
module sa4_data_store
  import sa4_cache_pkg::*;
#(
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int AW     = IDX_W + WAY_W + WSEL_W,
  localparam int DEPTH  = SETS * NUM_WAYS * LINE_WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data
);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     rd_ptr, wr_ptr;

  assign rd_ptr  = {idx, rd_way, rd_word};
  assign wr_ptr  = {idx, wr_way, wr_word};
  assign rd_data = mem_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_ptr] <= wr_data;
  end

endmodule

// File: rtl/sa4_ctrl.sv
module sa4_ctrl
  import sa4_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int BYPASS_BIT = 29,
  localparam int IDX_W   = $clog2(SETS),
  localparam int WSEL_W  = $clog2(LINE_WORDS),
  localparam int TAG_W   = ADDR_W - IDX_W - WSEL_W - 2,
  localparam int TAG_LSB = ADDR_W - TAG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0]   cpu_wdata,
  output logic [WORD_W-1:0]   cpu_rdata,
  output logic                cpu_ready,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                mem_ready,
  output logic [IDX_W-1:0]    lk_idx,
  output logic [TAG_W-1:0]    lk_tag,
  output logic [WSEL_W-1:0]   lk_word,
  input  logic [NUM_WAYS-1:0] hit_vec,
  input  logic [WAY_W-1:0]    victim,
  input  logic [WORD_W-1:0]   arr_rdata,
  output logic [WAY_W-1:0]    rd_way,
  output logic                touch_en,
  output logic [WAY_W-1:0]    touch_way,
  output logic                install_en,
  output logic [WAY_W-1:0]    install_way,
  output logic                dwe,
  output logic [WAY_W-1:0]    dway,
  output logic [WSEL_W-1:0]   dword,
  output logic [WORD_W-1:0]   dwdata
);

  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

  ctrl_state_e       state_q, state_d;
  logic [WSEL_W-1:0] cnt_q, cnt_d;
  logic [WAY_W-1:0]  vic_q, vic_d;
  logic              cnt_en, vic_en;
  logic              bypass, hit;
  logic [WAY_W-1:0]  hit_way;

  // address split; the window bit is cleared so both windows share lines
  always_comb begin
    bypass  = cpu_addr[BYPASS_BIT];
    lk_tag  = cpu_addr[ADDR_W-1:TAG_LSB];
    lk_tag[BYPASS_BIT-TAG_LSB] = 1'b0;
    lk_idx  = cpu_addr[TAG_LSB-1 -: IDX_W];
    lk_word = cpu_addr[2 +: WSEL_W];
    hit     = |hit_vec;
    hit_way = way_of(hit_vec);
  end

  assign rd_way    = hit_way;
  assign mem_wdata = cpu_wdata;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    vic_d       = vic_q;
    cnt_en      = 1'b0;
    vic_en      = 1'b0;
    cpu_ready   = 1'b0;
    cpu_rdata   = '0;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = cpu_addr;
    touch_en    = 1'b0;
    touch_way   = hit_way;
    install_en  = 1'b0;
    install_way = vic_q;
    dwe         = 1'b0;
    dway        = hit_way;
    dword       = lk_word;
    dwdata      = cpu_wdata;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (!bypass && !cpu_we) begin
            if (hit) begin
              cpu_ready = 1'b1;
              cpu_rdata = arr_rdata;
              touch_en  = 1'b1;
            end else begin
              state_d = ST_FILL;
              cnt_d   = '0;
              cnt_en  = 1'b1;
              vic_d   = victim;
              vic_en  = 1'b1;
            end
          end else begin
            state_d = ST_SINGLE;
          end
        end
      end
      ST_SINGLE: begin
        mem_req = 1'b1;
        mem_we  = cpu_we;
        if (mem_ready) begin
          cpu_ready = 1'b1;
          cpu_rdata = mem_rdata;
          state_d   = ST_IDLE;
          if (cpu_we && !bypass && hit) begin
            dwe      = 1'b1;
            touch_en = 1'b1;
          end
        end
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = {lk_tag, lk_idx, cnt_q, 2'b00};
        if (mem_ready) begin
          dwe    = 1'b1;
          dway   = vic_q;
          dword  = cnt_q;
          dwdata = mem_rdata;
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
          if (cnt_q == LAST_WORD) begin
            install_en = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vic_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (vic_en) vic_q <= vic_d;
    end
  end

endmodule

// File: rtl/sa4_cache.sv
module sa4_cache
  import sa4_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_WORDS = 4,
  parameter int BYPASS_BIT = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready
);

  localparam int IDX_W  = $clog2(SETS);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - 2;

  logic [IDX_W-1:0]    lk_idx;
  logic [TAG_W-1:0]    lk_tag;
  logic [WSEL_W-1:0]   lk_word;
  logic [NUM_WAYS-1:0] hit_vec;
  logic [WAY_W-1:0]    victim, rd_way, touch_way, install_way, dway;
  logic                touch_en, install_en, dwe;
  logic [WSEL_W-1:0]   dword;
  logic [WORD_W-1:0]   dwdata, arr_rdata;

  sa4_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SETS(SETS),
    .LINE_WORDS(LINE_WORDS), .BYPASS_BIT(BYPASS_BIT)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_word(lk_word),
    .hit_vec(hit_vec), .victim(victim), .arr_rdata(arr_rdata), .rd_way(rd_way),
    .touch_en(touch_en), .touch_way(touch_way),
    .install_en(install_en), .install_way(install_way),
    .dwe(dwe), .dway(dway), .dword(dword), .dwdata(dwdata)
  );

  sa4_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .hit_vec(hit_vec), .victim(victim),
    .touch_en(touch_en), .touch_way(touch_way),
    .install_en(install_en), .install_way(install_way)
  );

  sa4_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) data_i (
    .clk(clk), .idx(lk_idx), .rd_way(rd_way), .rd_word(lk_word), .rd_data(arr_rdata),
    .wr_en(dwe), .wr_way(dway), .wr_word(dword), .wr_data(dwdata)
  );

endmodule

// File: rtl/sa4_cache_checker.sv
module sa4_cache_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int BYPASS_BIT = 29,
  localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic [3:0]        hit_vec,
  input logic              dwe,
  input logic              install_en
);

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req); // R2

  AST_BYPASS_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_addr[BYPASS_BIT] && mem_req) |-> (mem_addr == cpu_addr)); // R6

  AST_BYPASS_NO_ARRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_addr[BYPASS_BIT]) |-> !dwe); // R7

  AST_FILL_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    install_en |-> (mem_ready && !mem_we && (&mem_addr[2 +: WSEL_W]))); // R3

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> (mem_req && mem_we && mem_ready)); // R8

  AST_SINGLE_HIT_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R10

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

endmodule

bind sa4_cache sa4_cache_checker #(
  .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .BYPASS_BIT(BYPASS_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_ready(mem_ready), .hit_vec(hit_vec), .dwe(dwe), .install_en(install_en)
);

// File: tb/sa4_cache_tb_top.sv
module sa4_cache_tb_top;

  localparam logic [31:0] WIN = 32'h2000_0000;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } op_t;

  logic        clk, rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  sa4_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] seed_word(input logic [31:0] k);
    return k ^ 32'hC3A5_0F1E;
  endfunction

  // physical memory behind the bus
  logic [31:0] phys_mem [logic [31:0]];
  logic [31:0] rsp_key;
  op_t         op_log [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
    end else if (mem_req) begin
      mem_ready <= 1'b1;
      rsp_key = mem_addr & ~WIN & ~32'h3;
      if (mem_we) phys_mem[rsp_key] = mem_wdata;
      else mem_rdata <= phys_mem.exists(rsp_key) ? phys_mem[rsp_key] : seed_word(rsp_key);
      op_log.push_back({mem_we, mem_addr, mem_we ? mem_wdata : 32'h0});
    end
  end

  // reference model
  logic [31:0] ref_mem [logic [31:0]];
  int          m_tag  [64][4];
  bit          m_val  [64][4];
  logic [31:0] m_dat  [64][4][4];
  bit   [2:0]  m_tree [64];
  op_t         exp_ops [$];

  function automatic logic [31:0] ref_rd(input logic [31:0] k);
    return ref_mem.exists(k) ? ref_mem[k] : seed_word(k);
  endfunction

  function automatic void m_touch(input int s, input int w);
    if (w < 2) begin m_tree[s][0] = 1'b1; m_tree[s][1] = (w == 0); end
    else       begin m_tree[s][0] = 1'b0; m_tree[s][2] = (w == 2); end
  endfunction

  function automatic int m_victim(input int s);
    for (int w = 0; w < 4; w++) if (!m_val[s][w]) return w;
    if (!m_tree[s][0]) return m_tree[s][1] ? 1 : 0;
    return m_tree[s][2] ? 3 : 2;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        input string req);
    logic [31:0] ph, exp_rd, got;
    int s, tg, wi, hw, v, guard;
    bit byp;
    ph = addr & ~WIN;
    byp = addr[29];
    s = int'(ph[9:4]);
    tg = int'(ph[31:10]);
    wi = int'(ph[3:2]);
    exp_ops.delete();
    hw = -1;
    for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == tg) hw = w;
    exp_rd = '0;
    if (we) begin
      exp_ops.push_back({1'b1, addr, wd});
      ref_mem[ph & ~32'h3] = wd;
      if (!byp && hw >= 0) begin m_dat[s][hw][wi] = wd; m_touch(s, hw); end
    end else if (byp) begin
      exp_ops.push_back({1'b0, addr, 32'h0});
      exp_rd = ref_rd(ph & ~32'h3);
    end else if (hw >= 0) begin
      exp_rd = m_dat[s][hw][wi];
      m_touch(s, hw);
    end else begin
      v = m_victim(s);
      for (int k = 0; k < 4; k++) begin
        logic [31:0] la;
        la = (ph & ~32'hF) | (k << 2);
        exp_ops.push_back({1'b0, la, 32'h0});
        m_dat[s][v][k] = ref_rd(la);
      end
      m_val[s][v] = 1'b1;
      m_tag[s][v] = tg;
      m_touch(s, v);
      exp_rd = m_dat[s][v][wi];
    end

    op_log.delete();
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    #1;
    guard = 0;
    while (!cpu_ready && guard < 100) begin
      @(negedge clk); #1; guard++;
    end
    got = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    check(guard < 100, req, "access completes", 32'(guard), 32'd100);
    if (!we) check(got == exp_rd, req, "read data", got, exp_rd);
    check(op_log.size() == exp_ops.size(), req, "memory transfer count",
          32'(op_log.size()), 32'(exp_ops.size()));
    if (op_log.size() == exp_ops.size())
      for (int i = 0; i < exp_ops.size(); i++)
        check(op_log[i] == exp_ops[i], req, "memory transfer", op_log[i].addr, exp_ops[i].addr);
  endtask

  // per-clock monitors
  logic        p_req, p_rdy, p_we;
  logic [31:0] p_addr;
  always @(negedge clk) begin
    if (rst_n) begin
      check(!cpu_ready || cpu_req, "R2", "ready without request", 32'(cpu_ready), 32'd0);
      if (p_req && !p_rdy)
        check(mem_req && mem_addr == p_addr && mem_we == p_we, "R11", "request held",
              mem_addr, p_addr);
      p_req = mem_req; p_rdy = mem_ready; p_addr = mem_addr; p_we = mem_we;
    end else begin
      p_req = 1'b0; p_rdy = 1'b0; p_addr = '0; p_we = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int s = 0; s < 64; s++) begin
      m_tree[s] = 3'b000;
      for (int w = 0; w < 4; w++) begin m_val[s][w] = 1'b0; m_tag[s][w] = 0; end
    end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!cpu_ready && !mem_req, "R1", "idle after reset", {cpu_ready, mem_req}, 32'd0);

    // R1: first read of any line must refill
    access(0, 32'h0000_1000, 0, "R1");
    access(0, 32'h0000_1004, 0, "R2");       // hit, no transfer
    access(0, 32'h0000_100C, 0, "R2");
    access(0, 32'h0000_1408, 0, "R3");       // miss, way 1
    access(0, 32'h0000_1800, 0, "R4");       // way 2
    access(0, 32'h0000_1C00, 0, "R4");       // way 3
    access(0, 32'h0000_1000, 0, "R5");       // touch way 0
    access(0, 32'h0000_2000, 0, "R4");       // evict per tree
    access(0, 32'h0000_1404, 0, "R5");
    access(0, 32'h0000_2400, 0, "R5");
    access(0, 32'h0000_1000, 0, "R5");
    // R10: bits 9:4 select the set
    access(0, 32'h0000_1010, 0, "R10");
    access(0, 32'h0000_13F0, 0, "R10");
    // R6: uncached read of a cached line
    access(0, WIN | 32'h0000_1004, 0, "R6");
    access(0, 32'h0000_1004, 0, "R6");
    // R7: uncached write leaves stale cached copy
    access(1, WIN | 32'h0000_1008, 32'hDEAD_BEEF, "R7");
    access(0, 32'h0000_1008, 0, "R7");
    access(0, WIN | 32'h0000_1008, 0, "R7");
    // R8: write hit, then write miss without allocation
    access(1, 32'h0000_1000, 32'h1234_5678, "R8");
    access(0, 32'h0000_1000, 0, "R8");
    access(1, 32'h0000_3040, 32'h0BAD_F00D, "R8");
    access(0, 32'h0000_3040, 0, "R8");
    // R9: test-and-set on a zero word
    access(1, 32'h0000_5080, 32'h0, "R9");
    access(0, 32'h0000_5080, 0, "R9");
    access(1, 32'h0000_5080, 32'h8000_0000, "R9");
    access(0, 32'h0000_5080, 0, "R9");
    access(0, 32'h0000_5080, 0, "R9");
    access(1, 32'h0000_5080, 32'h8000_0000, "R9");

    // R3 R4 R5 R6 R7 R8: mixed traffic over a few crowded sets
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = (32'(lf[2:0]) << 10) | (32'(lf[4:3]) << 4) | (32'(lf[6:5]) << 2);
      if (lf[9:7] == 3'd0) a = a | WIN;
      access(lf[12:10] < 3'd2, a, lf ^ 32'h5A5A_A5A5, "R5");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule